// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

This unit does one of two bit-field operations on the low 64-bit lane of a pair of 128-bit operands. An extract takes a contiguous run of bits out of operand X, shifts it down so its first bit lands at bit 0, and fills the rest of the lane with zeros. An insert overwrites a contiguous run of bits in X with the low-order bits of operand Y and leaves every other bit of X unchanged.

The field is described by a 6-bit length and a 6-bit start position, where the start position is the bit number of the field's least significant bit. These two values come from one of two places. In the embedded form they sit at fixed bit positions inside operand Y. In the immediate form they arrive on two dedicated ports.

A zero length stands for a full 64-bit field. The unit flags field descriptions that do not fit within the lane. The result is registered and appears one clock after the request.

Top module: `bitfield_unit`

## Requirements
- R1: With op_sel=0 (extract) and form_sel=0 (embedded form), the length is read from y_in[5:0] and the start position from y_in[13:8]. Every other bit of y_in and both immediate ports have no effect on the result.
- R2: With op_sel=1 (insert) and form_sel=0, the length is read from y_in[69:64] and the start position from y_in[77:72]. The inserted data is taken from the low bits of y_in[63:0], and the immediate ports have no effect.
- R3: With form_sel=1 (immediate form), the length is imm_len and the start position is imm_idx. The control bit positions inside y_in listed in R1 and R2 have no effect.
- R4: A length of 0 means 64 bits. With length 0 and start 0, an extract returns x_in[63:0], and an insert returns y_in[63:0].
- R5: An extract returns the field x_in[idx+len-1:idx] right-justified and zero-extended in result[63:0]. For example, length 8 at start 8 of 0x0123456789abcdef gives 0xcd.
- R6: An insert places y_in[len-1:0] at bits [idx+len-1:idx] of x_in[63:0] and keeps all other bits of x_in[63:0]. For example, length 8 at start 8 of 0x0011223344556677 into 0x0123456789abcdef gives 0x0123456789ab77ef.
- R7: A field with length 0 and a nonzero start, or with length+start > 64, sets illegal=1 and forces the whole result to zero. Legal fields give illegal=0.
- R8: result[127:64] is always zero.
- R9: out_valid is high exactly one clock after in_valid is high. result and illegal belong to that request and are held while no new request arrives.
- R10: A synchronous active-high rst clears out_valid, result and illegal at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 1 | 0 = extract, 1 = insert |
| form_sel | input | 1 | 0 = field taken from y_in, 1 = field taken from immediate ports |
| x_in | input | 128 | Operand X; only bits [63:0] are used |
| y_in | input | 128 | Operand Y: insert data and embedded field controls |
| imm_len | input | 6 | Immediate field length (0 means 64) |
| imm_idx | input | 6 | Immediate field start position |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| result | output | 128 | Registered result, upper half zero |
| illegal | output | 1 | Field description did not fit the lane |

## Verification
The bench builds the unit with its default 64-bit lane width. That is the only width at which the embedded control positions at bits 8, 64 and 72 line up with the operand layout the requirements describe.

At this width the 6-bit length and start ports cover every encoding, so the checks can reach the following cases:
- the zero-length full-lane case;
- fields that end exactly on bit 63;
- fields that run one bit past bit 63;
- a zero length with a nonzero start.

Random requests with noise in the ignored control bits are compared against a behavioural bit-loop model on every clock.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

    typedef enum logic {
        BF_EXTRACT = 1'b0,
        BF_INSERT  = 1'b1
    } bf_op_e;

    typedef enum logic {
        BF_FORM_EMBED = 1'b0,
        BF_FORM_IMM   = 1'b1
    } bf_form_e;

    // Bit offset of the start-position control above the length control
    localparam int unsigned BF_IDX_OFS = 8;

endpackage

// File: rtl/bfu_field_sel.sv
module bfu_field_sel
    import bfu_pkg::*;
#(
    parameter  int unsigned LANE_W = 64,
    localparam int unsigned CTL_W  = $clog2(LANE_W),
    localparam int unsigned OP_W   = 2 * LANE_W
) (
    input  logic             op_sel,
    input  logic             form_sel,
    input  logic [OP_W-1:0]  y_in,
    input  logic [CTL_W-1:0] imm_len,
    input  logic [CTL_W-1:0] imm_idx,
    output logic [CTL_W-1:0] fld_len,
    output logic [CTL_W-1:0] fld_idx
);

    localparam int unsigned EXT_LEN_POS = 0;
    localparam int unsigned EXT_IDX_POS = EXT_LEN_POS + BF_IDX_OFS;
    localparam int unsigned INS_LEN_POS = LANE_W;
    localparam int unsigned INS_IDX_POS = INS_LEN_POS + BF_IDX_OFS;

    logic [CTL_W-1:0] emb_len;
    logic [CTL_W-1:0] emb_idx;

    always_comb begin
        if (bf_op_e'(op_sel) == BF_INSERT) begin
            emb_len = y_in[INS_LEN_POS +: CTL_W];
            emb_idx = y_in[INS_IDX_POS +: CTL_W];
        end else begin
            emb_len = y_in[EXT_LEN_POS +: CTL_W];
            emb_idx = y_in[EXT_IDX_POS +: CTL_W];
        end
    end

    always_comb begin
        if (bf_form_e'(form_sel) == BF_FORM_IMM) begin
            fld_len = imm_len;
            fld_idx = imm_idx;
        end else begin
            fld_len = emb_len;
            fld_idx = emb_idx;
        end
    end

endmodule

// File: rtl/bfu_field_check.sv
module bfu_field_check #(
    parameter  int unsigned LANE_W = 64,
    localparam int unsigned CTL_W  = $clog2(LANE_W)
) (
    input  logic [CTL_W-1:0]  fld_len,
    input  logic [CTL_W-1:0]  fld_idx,
    output logic [LANE_W-1:0] len_mask,
    output logic              bad_field
);

    localparam int unsigned SUM_W = CTL_W + 2;

    logic [CTL_W:0] eff_len;
    logic [SUM_W-1:0] fld_end;
    logic zero_len;

    always_comb begin
        zero_len = (fld_len == '0);
        eff_len  = zero_len ? (CTL_W + 1)'(LANE_W) : {1'b0, fld_len};
        fld_end  = SUM_W'(eff_len) + SUM_W'(fld_idx);
        bad_field = (zero_len && (fld_idx != '0)) || (fld_end > SUM_W'(LANE_W));
    end

    for (genvar b = 0; b < LANE_W; b++) begin : g_mask
        assign len_mask[b] = ((CTL_W + 1)'(b) < eff_len);
    end

endmodule

// File: rtl/bfu_extract.sv
module bfu_extract #(
    parameter  int unsigned LANE_W = 64,
    localparam int unsigned CTL_W  = $clog2(LANE_W)
) (
    input  logic [LANE_W-1:0] x_lo,
    input  logic [CTL_W-1:0]  fld_idx,
    input  logic [LANE_W-1:0] len_mask,
    output logic [LANE_W-1:0] ext_out
);

    logic [LANE_W-1:0] shifted;

    always_comb begin
        shifted = x_lo >> fld_idx;
        ext_out = shifted & len_mask;
    end

endmodule

// File: rtl/bfu_insert.sv
module bfu_insert #(
    parameter  int unsigned LANE_W = 64,
    localparam int unsigned CTL_W  = $clog2(LANE_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LANE_W-1:0] x_lo,
    input  logic [LANE_W-1:0] y_lo,
    input  logic [CTL_W-1:0]  fld_idx,
    input  logic [LANE_W-1:0] len_mask,
    input  logic              bad_field,
    output logic [LANE_W-1:0] ins_out
);

    logic [LANE_W-1:0] hole;
    logic [LANE_W-1:0] payload;

    always_comb begin
        hole    = len_mask << fld_idx;
        payload = (y_lo & len_mask) << fld_idx;
        ins_out = (x_lo & ~hole) | payload;
    end

    // R6: bits outside the field come from X unchanged
    p_insert_keeps_rest_r6: assert property (@(posedge clk) disable iff (rst)
        !bad_field |-> (((ins_out ^ x_lo) & ~(len_mask << fld_idx)) == '0));

endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
    import bfu_pkg::*;
#(
    parameter  int unsigned LANE_W = 64,
    localparam int unsigned CTL_W  = $clog2(LANE_W),
    localparam int unsigned OP_W   = 2 * LANE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             op_sel,
    input  logic             form_sel,
    input  logic [OP_W-1:0]  x_in,
    input  logic [OP_W-1:0]  y_in,
    input  logic [CTL_W-1:0] imm_len,
    input  logic [CTL_W-1:0] imm_idx,
    output logic             out_valid,
    output logic [OP_W-1:0]  result,
    output logic             illegal
);

    typedef struct packed {
        logic             vld;
        logic             ill;
        logic [OP_W-1:0]  res;
    } stage_t;

    stage_t stage_d, stage_q;

    logic [CTL_W-1:0]  fld_len;
    logic [CTL_W-1:0]  fld_idx;
    logic [LANE_W-1:0] len_mask;
    logic              bad_field;
    logic [LANE_W-1:0] ext_out;
    logic [LANE_W-1:0] ins_out;

    bfu_field_sel #(.LANE_W(LANE_W)) u_sel (
        .op_sel   (op_sel),
        .form_sel (form_sel),
        .y_in     (y_in),
        .imm_len  (imm_len),
        .imm_idx  (imm_idx),
        .fld_len  (fld_len),
        .fld_idx  (fld_idx)
    );

    bfu_field_check #(.LANE_W(LANE_W)) u_chk (
        .fld_len   (fld_len),
        .fld_idx   (fld_idx),
        .len_mask  (len_mask),
        .bad_field (bad_field)
    );

    bfu_extract #(.LANE_W(LANE_W)) u_ext (
        .x_lo     (x_in[LANE_W-1:0]),
        .fld_idx  (fld_idx),
        .len_mask (len_mask),
        .ext_out  (ext_out)
    );

    bfu_insert #(.LANE_W(LANE_W)) u_ins (
        .clk       (clk),
        .rst       (rst),
        .x_lo      (x_in[LANE_W-1:0]),
        .y_lo      (y_in[LANE_W-1:0]),
        .fld_idx   (fld_idx),
        .len_mask  (len_mask),
        .bad_field (bad_field),
        .ins_out   (ins_out)
    );

    always_comb begin
        stage_d     = stage_q;
        stage_d.vld = in_valid;
        if (in_valid) begin
            stage_d.ill = bad_field;
            if (bad_field) begin
                stage_d.res = '0;
            end else if (bf_op_e'(op_sel) == BF_INSERT) begin
                stage_d.res = {{LANE_W{1'b0}}, ins_out};
            end else begin
                stage_d.res = {{LANE_W{1'b0}}, ext_out};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid = stage_q.vld;
    assign result    = stage_q.res;
    assign illegal   = stage_q.ill;

    // R9: one-clock latency from request to result
    p_valid_follows_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_no_spurious_valid_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R9: result held between requests
    p_result_held_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));
    // R8: upper half is zero
    p_upper_zero_r8: assert property (@(posedge clk) disable iff (rst)
        result[OP_W-1:LANE_W] == '0);
    // R7: an illegal field yields a zero result
    p_illegal_zero_r7: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (result == '0));
    // R10: reset clears the output stage
    p_reset_clears_r10: assert property (@(posedge clk)
        rst |=> (!out_valid && !illegal && result == '0));

endmodule

// File: tb/bitfield_unit_bench.sv
`timescale 1ns/1ps
module bitfield_unit_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         op_sel = 1'b0;
    logic         form_sel = 1'b0;
    logic [127:0] x_in = '0;
    logic [127:0] y_in = '0;
    logic [5:0]   imm_len = '0;
    logic [5:0]   imm_idx = '0;
    logic         out_valid;
    logic [127:0] result;
    logic         illegal;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bitfield_unit u_bitfield_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .form_sel(form_sel), .x_in(x_in), .y_in(y_in), .imm_len(imm_len),
        .imm_idx(imm_idx), .out_valid(out_valid), .result(result),
        .illegal(illegal)
    );

    task automatic check(input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Behavioural model, bit by bit
    function automatic void model(input bit op, input bit form,
                                  input logic [127:0] x, input logic [127:0] y,
                                  input logic [5:0] il, input logic [5:0] ii,
                                  output logic [127:0] r, output bit bad);
        int len, idx, le;
        if (form) begin
            len = il; idx = ii;
        end else if (op) begin
            len = y[69:64]; idx = y[77:72];
        end else begin
            len = y[5:0]; idx = y[13:8];
        end
        le  = (len == 0) ? 64 : len;
        bad = (len == 0 && idx != 0) || (le + idx > 64);
        r = '0;
        if (!bad) begin
            for (int i = 0; i < 64; i++) begin
                if (!op) begin
                    if (i < le) r[i] = x[idx + i];
                end else if (i >= idx && i < idx + le) begin
                    r[i] = y[i - idx];
                end else begin
                    r[i] = x[i];
                end
            end
        end
    endfunction

    task automatic issue(input string req, input bit op, input bit form,
                         input logic [127:0] x, input logic [127:0] y,
                         input logic [5:0] il, input logic [5:0] ii);
        logic [127:0] er;
        bit eb;
        model(op, form, x, y, il, ii, er, eb);
        op_sel = op; form_sel = form; x_in = x; y_in = y;
        imm_len = il; imm_idx = ii; in_valid = 1'b1;
        @(posedge clk); #1;
        in_valid = 1'b0;
        check({req, " R9 valid"}, 128'(out_valid), 128'd1);
        check({req, " result"}, result, er);
        check({req, " R7 flag"}, 128'(illegal), 128'(eb));
        check({req, " R8 upper"}, 128'(result[127:64]), 128'd0);
    endtask

    task automatic idle_cycle(input logic [127:0] held);
        x_in = {$urandom, $urandom, $urandom, $urandom};
        @(posedge clk); #1;
        check("R9 idle valid", 128'(out_valid), 128'd0);
        check("R9 held result", result, held);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset valid", 128'(out_valid), 128'd0);
        check("R10 reset result", result, 128'd0);
        check("R10 reset flag", 128'(illegal), 128'd0);
        rst = 1'b0;
        @(posedge clk); #1;
        check("R9 no request", 128'(out_valid), 128'd0);

        // R5 extract examples, immediate and embedded forms
        issue("R5 R3 imm extract", 0, 1, 128'h0123456789abcdef, '0, 6'd8, 6'd8);
        check("R5 value", result, 128'hcd);
        issue("R1 embedded extract", 0, 0, 128'h600,
              {64'hffff_ffff_ffff_ffff, 64'hffff_0000_0000_0804}, 6'd33, 6'd7);
        check("R1 value", result, 128'h6);
        idle_cycle(128'h6);
        // R6 insert examples
        issue("R6 R3 imm insert", 1, 1, 128'h0123456789abcdef,
              {64'hffff, 64'h0011223344556677}, 6'd8, 6'd8);
        check("R6 value", result, 128'h0123456789ab77ef);
        issue("R2 embedded insert", 1, 0, 128'haaa,
              {64'h0000_0000_0000_0804, 64'h6}, 6'd40, 6'd3);
        check("R2 value", result, 128'h6aa);
        // R4 zero length means 64
        issue("R4 extract full", 0, 1, {64'h1, 64'hdeadbeefcafef00d}, '0, 6'd0, 6'd0);
        check("R4 extract value", result, 128'hdeadbeefcafef00d);
        issue("R4 insert full", 1, 0, 128'h1234, {64'h0, 64'h8765432112345678}, 6'd5, 6'd5);
        check("R4 insert value", result, 128'h8765432112345678);
        // R7 boundaries
        issue("R7 zero len nonzero idx", 0, 1, 128'hffff, '0, 6'd0, 6'd5);
        check("R7 flagged", 128'(illegal), 128'd1);
        issue("R7 end at 63", 0, 1, 128'hf000_0000_0000_0000, '0, 6'd4, 6'd60);
        check("R7 legal edge", result, 128'hf);
        issue("R7 one past", 1, 1, 128'hffff, 128'h3, 6'd5, 6'd60);
        check("R7 past flagged", 128'(illegal), 128'd1);
        idle_cycle('0);

        for (int n = 0; n < 400; n++) begin
            issue("R3 random", 1'($urandom), 1'($urandom),
                  {$urandom, $urandom, $urandom, $urandom},
                  {$urandom, $urandom, $urandom, $urandom},
                  6'($urandom), 6'($urandom % 24));
            if (n % 7 == 0) idle_cycle(result);
        end

        // R10 mid-run reset
        issue("R10 pre", 0, 1, 128'hff, '0, 6'd8, 6'd0);
        rst = 1'b1;
        @(posedge clk); #1;
        check("R10 clears result", result, 128'd0);
        check("R10 clears valid", 128'(out_valid), 128'd0);
        rst = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule